// File: doc/BRIEF.md
# Transfer Byte Counter with Host Address Tracker

This block keeps two running quantities for a data transfer across a device bus. The first is a 24-bit count of the bytes still to be moved, which counts down. The second is a 32-bit host address for the next byte, which counts up. Both counters move on the same clock edge, and only when the transfer logic reports that a byte has completed safely. Issuing a byte does not move them. The block flags when the count is zero. A sticky flag records that the count went below zero and wrapped.

Software sees the block through a byte-wide register port. The count bytes can be written and read back. The address bytes can only be read. The address itself is seeded from the host side through a separate load input. The zero flag follows the count. The wrap flag stays set until a clear strobe removes it. The clear strobes come from a control register elsewhere. The bus handshake, the FIFO, the DMA engine and interrupt collection sit outside this block.

Top module: `xfer_count_tracker`

## Requirements
- R1: After reset the count is 0, the address is 0, `count_zero` is 1 and `wrap_flag` is 0.
- R2: The count bytes sit at register addresses 0, 1 and 2, with address 0 holding bits 7:0. A write to one of these addresses replaces only that byte. A read returns the current byte.
- R3: The address bytes sit at register addresses 4 to 7, with address 4 holding bits 7:0. Writes to addresses 3 to 7 change neither counter. A read of address 3 returns 0.
- R4: The count drops by exactly 1 in the cycle after `xfer_done` is high. Otherwise it holds, unless it is written or cleared.
- R5: Each time the count steps, the address rises by exactly 1 in the same cycle. The address wraps from 0xFFFFFFFF to 0.
- R6: `count_zero` is high exactly when the count equals 0.
- R7: A step taken while the count is 0 gives a count of 0xFFFFFF and sets `wrap_flag`. The flag then stays set across further loads and steps.
- R8: A `clr_wrap` pulse clears `wrap_flag` in the next cycle.
- R9: If a wrap and `clr_wrap` fall in the same cycle, `wrap_flag` ends up set.
- R10: `clr_count` forces the count to 0 and has the highest priority. In that cycle no step takes place, so the address and the wrap flag are untouched.
- R11: A count-byte write in the same cycle as `xfer_done` wins. The written value is stored without a decrement, and the address does not step.
- R12: `addr_load` replaces the address with `addr_load_val` and overrides that cycle's increment. The count still steps if `xfer_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_done | input | 1 | One byte confirmed as transferred |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte address for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at `reg_addr` |
| clr_count | input | 1 | Clear the transfer count |
| clr_wrap | input | 1 | Clear the wrap flag |
| addr_load | input | 1 | Load the host address |
| addr_load_val | input | 32 | Host address value to load |
| count_zero | output | 1 | Count equals zero |
| wrap_flag | output | 1 | Sticky count-wrap indication |

## Verification
The bench loads every small count from 0 to 5 and steps each one past zero. It checks all bytes of both counters after every step.

- **Borrow and carry:** the bench drives a borrow that crosses byte lanes and an address carry out of 0xFFFFFFFF. A design with a broken lane borrow or carry would show a wrong upper byte.
- **Same-cycle collisions:** the bench drives write with step, clear with step, address load with step, and wrap with wrap-clear. A design with the wrong priority would decrement a freshly written count, step the address without a decrement, or lose a wrap event.
- **Read-only and unmapped addresses:** the bench writes to the read-only address bytes and to the hole at address 3. A design with a loose decoder would corrupt a counter on those writes.

// File: rtl/xct_pkg.sv
package xct_pkg;

   typedef enum logic [1:0] {
      CNT_HOLD  = 2'd0,
      CNT_CLEAR = 2'd1,
      CNT_LOAD  = 2'd2,
      CNT_STEP  = 2'd3
   } cnt_op_e;

   localparam int BYTE_W = 8;

   function automatic int ceil_pow2(input int n);
      int p;
      p = 1;
      while (p < n) p = p * 2;
      return p;
   endfunction

   function automatic int clog2_min1(input int n);
      int b;
      b = 1;
      while ((1 << b) < n) b = b + 1;
      return b;
   endfunction

endpackage

// File: rtl/xct_down_counter.sv
module xct_down_counter #(
   parameter int NBYTES = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  xct_pkg::cnt_op_e      op,
   input  logic [NBYTES-1:0]     lane_we,
   input  logic [7:0]            wdata,
   output logic [8*NBYTES-1:0]   cnt_q,
   output logic                  is_zero,
   output logic                  underflow
);
   localparam int W = 8 * NBYTES;

   logic [W-1:0] load_val;
   logic [W-1:0] cnt_d;

   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      assign load_val[8*i +: 8] = lane_we[i] ? wdata : cnt_q[8*i +: 8];
   end

   always_comb begin
      case (op)
         xct_pkg::CNT_CLEAR: cnt_d = '0;
         xct_pkg::CNT_LOAD:  cnt_d = load_val;
         xct_pkg::CNT_STEP:  cnt_d = cnt_q - 1'b1;
         default:            cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign is_zero   = (cnt_q == '0);
   assign underflow = (op == xct_pkg::CNT_STEP) && is_zero;

endmodule

// File: rtl/xct_up_counter.sv
module xct_up_counter #(
   parameter int W    = 32,
   parameter int STEP = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] q
);
   logic [W-1:0] q_inc;

   if (STEP == 1) begin : g_unit
      assign q_inc = q + 1'b1;
   end else begin : g_stride
      assign q_inc = q + W'(STEP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (step) q <= q_inc;
   end

endmodule

// File: rtl/xct_byte_mux.sv
module xct_byte_mux #(
   parameter int CNT_BYTES  = 3,
   parameter int ADDR_BYTES = 4,
   parameter int REG_AW     = 3,
   parameter int ADDR_BASE  = 4
) (
   input  logic [8*CNT_BYTES-1:0]  cnt,
   input  logic [8*ADDR_BYTES-1:0] addr,
   input  logic [REG_AW-1:0]       sel,
   output logic [7:0]              rdata
);
   localparam int DEPTH = 1 << REG_AW;

   logic [7:0] tbl [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i < CNT_BYTES) begin : g_cnt
         assign tbl[i] = cnt[8*i +: 8];
      end else if (i >= ADDR_BASE && i < ADDR_BASE + ADDR_BYTES) begin : g_addr
         assign tbl[i] = addr[8*(i-ADDR_BASE) +: 8];
      end else begin : g_hole
         assign tbl[i] = 8'h00;
      end
   end

   assign rdata = tbl[sel];

endmodule

// File: rtl/xfer_count_tracker.sv
module xfer_count_tracker #(
   parameter int CNT_BYTES  = 3,
   parameter int ADDR_BYTES = 4,
   parameter int REG_AW     = 3,
   parameter int ADDR_STEP  = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    xfer_done,
   input  logic                    reg_wr,
   input  logic [REG_AW-1:0]       reg_addr,
   input  logic [7:0]              reg_wdata,
   output logic [7:0]              reg_rdata,
   input  logic                    clr_count,
   input  logic                    clr_wrap,
   input  logic                    addr_load,
   input  logic [8*ADDR_BYTES-1:0] addr_load_val,
   output logic                    count_zero,
   output logic                    wrap_flag
);
   localparam int CW        = 8 * CNT_BYTES;
   localparam int AW        = 8 * ADDR_BYTES;
   localparam int ADDR_BASE = xct_pkg::ceil_pow2(CNT_BYTES);

   if (CNT_BYTES < 1) begin : g_bad_cnt
      $error("CNT_BYTES must be at least 1");
   end
   if (ADDR_BYTES < 1) begin : g_bad_addr
      $error("ADDR_BYTES must be at least 1");
   end
   if (ADDR_BASE + ADDR_BYTES > (1 << REG_AW)) begin : g_bad_map
      $error("REG_AW too small for the register map");
   end
   if (ADDR_STEP < 1) begin : g_bad_step
      $error("ADDR_STEP must be positive");
   end

   logic [CNT_BYTES-1:0] lane_we;
   logic                 cnt_wr;
   xct_pkg::cnt_op_e     op;
   logic [CW-1:0]        cnt_q;
   logic [AW-1:0]        addr_q;
   logic                 underflow;
   logic                 step;

   for (genvar i = 0; i < CNT_BYTES; i++) begin : g_dec
      assign lane_we[i] = reg_wr && (reg_addr == REG_AW'(i));
   end
   assign cnt_wr = |lane_we;

   always_comb begin
      if (clr_count)      op = xct_pkg::CNT_CLEAR;
      else if (cnt_wr)    op = xct_pkg::CNT_LOAD;
      else if (xfer_done) op = xct_pkg::CNT_STEP;
      else                op = xct_pkg::CNT_HOLD;
   end

   assign step = (op == xct_pkg::CNT_STEP);

   xct_down_counter #(.NBYTES(CNT_BYTES)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .lane_we   (lane_we),
      .wdata     (reg_wdata),
      .cnt_q     (cnt_q),
      .is_zero   (count_zero),
      .underflow (underflow)
   );

   xct_up_counter #(.W(AW), .STEP(ADDR_STEP)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (addr_load),
      .load_val (addr_load_val),
      .step     (step),
      .q        (addr_q)
   );

   xct_byte_mux #(
      .CNT_BYTES (CNT_BYTES),
      .ADDR_BYTES(ADDR_BYTES),
      .REG_AW    (REG_AW),
      .ADDR_BASE (ADDR_BASE)
   ) u_rd (
      .cnt   (cnt_q),
      .addr  (addr_q),
      .sel   (reg_addr),
      .rdata (reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wrap_flag <= 1'b0;
      else if (underflow) wrap_flag <= 1'b1;
      else if (clr_wrap)  wrap_flag <= 1'b0;
   end

endmodule

// File: rtl/xfer_count_tracker_chk.sv
module xfer_count_tracker_chk #(
   parameter int CNT_BYTES  = 3,
   parameter int ADDR_BYTES = 4,
   parameter int REG_AW     = 3,
   parameter int ADDR_STEP  = 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    xfer_done,
   input logic                    reg_wr,
   input logic [REG_AW-1:0]       reg_addr,
   input logic                    clr_count,
   input logic                    clr_wrap,
   input logic                    addr_load,
   input logic [8*ADDR_BYTES-1:0] addr_load_val,
   input logic                    count_zero,
   input logic                    wrap_flag,
   input logic [8*CNT_BYTES-1:0]  cnt_q,
   input logic [8*ADDR_BYTES-1:0] addr_q
);
   localparam int CW = 8 * CNT_BYTES;
   localparam int AW = 8 * ADDR_BYTES;

   logic wr_hit;
   logic stepping;
   assign wr_hit   = reg_wr && (32'(reg_addr) < CNT_BYTES);
   assign stepping = xfer_done && !clr_count && !wr_hit;

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stepping |=> cnt_q == CW'($past(cnt_q) - 1'b1));

   // R4
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_done && !clr_count && !wr_hit) |=> $stable(cnt_q));

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stepping && !addr_load) |=> addr_q == AW'($past(addr_q) + AW'(ADDR_STEP)));

   // R7
   wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stepping && count_zero) |=> wrap_flag && (cnt_q == {CW{1'b1}}));

   // R8
   wrap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wrap && !(stepping && count_zero)) |=> !wrap_flag);

   // R10
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_count |=> count_zero && $stable(wrap_flag));

   // R12
   addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_load |=> addr_q == $past(addr_load_val));

endmodule

bind xfer_count_tracker xfer_count_tracker_chk #(
   .CNT_BYTES (CNT_BYTES),
   .ADDR_BYTES(ADDR_BYTES),
   .REG_AW    (REG_AW),
   .ADDR_STEP (ADDR_STEP)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .xfer_done    (xfer_done),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .clr_count    (clr_count),
   .clr_wrap     (clr_wrap),
   .addr_load    (addr_load),
   .addr_load_val(addr_load_val),
   .count_zero   (count_zero),
   .wrap_flag    (wrap_flag),
   .cnt_q        (cnt_q),
   .addr_q       (addr_q)
);

// File: tb/xfer_count_tracker_bench.sv
`timescale 1ns/1ps
module xfer_count_tracker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_done = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        clr_count = 1'b0;
   logic        clr_wrap = 1'b0;
   logic        addr_load = 1'b0;
   logic [31:0] addr_load_val = '0;
   logic        count_zero;
   logic        wrap_flag;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [23:0] exp_cnt = '0;
   logic [31:0] exp_addr = '0;
   logic        exp_wrap = 1'b0;

   always #2.5 clk = ~clk;

   xfer_count_tracker u_xfer_count_tracker (
      .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .clr_count(clr_count), .clr_wrap(clr_wrap), .addr_load(addr_load),
      .addr_load_val(addr_load_val), .count_zero(count_zero), .wrap_flag(wrap_flag)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #0.3;
      d = reg_rdata;
   endtask

   task automatic check_all(input string req);
      logic [7:0]  b;
      logic [23:0] c;
      logic [31:0] a;
      for (int i = 0; i < 3; i++) begin rd(3'(i), b); c[8*i +: 8] = b; end
      for (int i = 0; i < 4; i++) begin rd(3'(4+i), b); a[8*i +: 8] = b; end
      chk(req, "count", 32'(c), 32'(exp_cnt));
      chk(req, "addr", a, exp_addr);
      chk(req, "zero(R6)", 32'(count_zero), 32'(exp_cnt == 0));
      chk(req, "wrap", 32'(wrap_flag), 32'(exp_wrap));
   endtask

   // drive one cycle of stimulus and advance the reference model
   task automatic drive(input logic xd, input logic wr, input logic [2:0] wa,
                        input logic [7:0] wd, input logic cc, input logic cw,
                        input logic al, input logic [31:0] av);
      logic hit, stp;
      xfer_done = xd; reg_wr = wr; reg_addr = wa; reg_wdata = wd;
      clr_count = cc; clr_wrap = cw; addr_load = al; addr_load_val = av;
      @(posedge clk);
      #1;
      xfer_done = 0; reg_wr = 0; clr_count = 0; clr_wrap = 0; addr_load = 0;
      hit = wr && (wa < 3);
      stp = xd && !cc && !hit;
      if (stp && exp_cnt == 0) exp_wrap = 1'b1;
      else if (cw) exp_wrap = 1'b0;
      if (cc) exp_cnt = '0;
      else if (hit) exp_cnt[8*wa +: 8] = wd;
      else if (stp) exp_cnt = exp_cnt - 1'b1;
      if (al) exp_addr = av;
      else if (stp) exp_addr = exp_addr + 1;
   endtask

   task automatic step1();
      drive(1, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic load_cnt(input logic [23:0] v);
      for (int i = 0; i < 3; i++) drive(0, 1, 3'(i), v[8*i +: 8], 0, 0, 0, 0);
   endtask

   initial begin
      logic [7:0] b;
      #12 rst_n = 1'b1;
      @(posedge clk); #1;
      check_all("R1");

      // R2: byte lanes, LSB at address 0
      load_cnt(24'h563412);
      check_all("R2");
      drive(0, 1, 1, 8'hA5, 0, 0, 0, 0);
      check_all("R2");

      // R3: address bytes are read-only, hole reads zero
      for (int i = 3; i < 8; i++) drive(0, 1, 3'(i), 8'hEE, 0, 0, 0, 0);
      check_all("R3");
      rd(3, b);
      chk("R3", "hole", 32'(b), 0);

      // R12: seed address
      drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_00FE);
      check_all("R12");

      // R4 R5 R6 R7: sweep small counts through zero
      for (int n = 0; n < 6; n++) begin
         load_cnt(24'(n));
         check_all("R6");
         for (int k = 0; k <= n; k++) begin
            step1();
            check_all(k == n ? "R7" : "R4");
         end
      end

      // R4: no confirmation, no movement
      for (int i = 0; i < 3; i++) begin
         drive(0, 0, 0, 0, 0, 0, 0, 0);
         check_all("R4");
      end

      // R4: borrow across lanes; R5: address carry-out wrap
      load_cnt(24'h010000);
      drive(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
      step1();
      check_all("R5");

      // R8: clear wrap
      drive(0, 0, 0, 0, 0, 1, 0, 0);
      check_all("R8");

      // R9: wrap and clear together
      load_cnt(24'h0);
      drive(1, 0, 0, 0, 0, 1, 0, 0);
      check_all("R9");

      // R10: clear count with step pending
      drive(0, 0, 0, 0, 0, 1, 0, 0);
      load_cnt(24'h000003);
      drive(1, 0, 0, 0, 1, 0, 0, 0);
      check_all("R10");

      // R11: write beats step
      drive(1, 1, 0, 8'h40, 0, 0, 0, 0);
      check_all("R11");

      // R12: address load beats increment, count still steps
      drive(1, 0, 0, 0, 0, 0, 1, 32'h1234_5678);
      check_all("R12");
      step1();
      check_all("R5");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule